// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits in front of a page-programmable non-volatile array. It watches a stream of bus writes that arrive already synchronised, one write per cycle of `wr_valid`, each with a 17-bit address and a data byte. It sorts them into unlock command sequences and plain data writes. A finished sequence produces a one-cycle command pulse: open a protected page write, drop protection, erase the chip, enter identification mode or leave it.

The decoder holds two flags that last across sequences. One is the global write-protect flag. The other is the identification-mode flag. While protection is on, a plain write goes to the page buffer only inside the window that a page-write command opens. Any other plain write is rejected, and the rejection locks the decoder out for a programmable number of cycles. While identification mode is active, a read port answers with the manufacturer code or the device code.

All registered outputs change on the clock edge that takes the completing write. The identification read path is combinational.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, protection is off, identification mode is off, the lockout is inactive, the page window is closed and no pulse, load or reject is asserted.
- R2: Within a sequence, only address bits 14:0 are compared. Bits 16 and 15 have no effect on recognition.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h raise `pulse_page_wr` and set protection. They also open a page window. This happens whether protection was on or off.
- R4: After AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh comes a sixth write at 5555h that picks the command. Data 10h raises `pulse_erase`. Data 20h raises `pulse_unprotect` and clears protection. Data 60h raises `pulse_id_enter` and sets identification mode. Any other sixth write ends the sequence without a command.
- R5: The third write 90h@5555h raises `pulse_id_enter` and sets identification mode. The third write F0h@5555h raises `pulse_id_exit` and clears it.
- R6: In identification mode, `rd_addr` with bits 14:1 all zero sets `id_hit`. `id_data` is then BFh when bit 0 is 0 and 07h when bit 0 is 1. Any other address, or identification mode being off, gives `id_hit` = 0.
- R7: With protection off, a plain write raises `load_valid` for one cycle, with its address and data on `load_addr`/`load_data`.
- R8: With protection on and the window closed, a plain write raises `load_reject` and produces no load. `lock_busy` then stays high for exactly LOCK_CYCLES cycles. Every write during that time is ignored, including command sequences.
- R9: In an open window every write is loaded without decoding. The window stays open while each write comes no more than WIN_GAP cycles after the previous one or after the command. It closes after WIN_GAP write-free cycles.
- R10: A write that does not match the next expected address/data pair returns the decoder to idle. The same write is then re-evaluated: AAh@5555h starts a new sequence, and anything else is handled as a plain write.
- R11: Writes consumed by a sequence never appear as loads.
- R12: At most one command pulse is high in any cycle. Each pulse follows the completing write by one cycle and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 17 | Read address for identification answers |
| load_valid | output | 1 | Write forwarded to the page buffer |
| load_addr | output | 17 | Address of the forwarded write |
| load_data | output | 8 | Data of the forwarded write |
| load_reject | output | 1 | Plain write refused under protection |
| lock_busy | output | 1 | Lockout after a refused write |
| prot_on | output | 1 | Global write-protect flag |
| id_mode | output | 1 | Identification mode flag |
| id_hit | output | 1 | Read address answered with an identification code |
| id_data | output | 8 | Identification code |
| pulse_page_wr | output | 1 | Protected page write opened |
| pulse_unprotect | output | 1 | Protection disabled |
| pulse_erase | output | 1 | Chip erase requested |
| pulse_id_enter | output | 1 | Identification entry |
| pulse_id_exit | output | 1 | Identification exit |

## Verification
Every command is driven through its full three- or six-write sequence. Some runs set address bits 16:15, which shows that only the low 15 bits are decoded. Broken sequences are used too. A data byte after a valid prefix tells the two miss outcomes apart: a stray write is forwarded as a load, while a repeated AAh@5555h restarts the sequence. Page writes are placed exactly WIN_GAP cycles after the previous write and then one cycle later, which separates an open window from a closed one. A six-write unprotect sent during a lockout shows that the lockout hides commands as well as data.

// File: rtl/unlock_pkg.sv
// Shared constants and types of the unlock sequence decoder.
// Assumes a byte-wide data bus; key codes are fixed bytes.
package unlock_pkg;
    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] ADR_KEY1 = 15'h5555;
    localparam logic [CMP_W-1:0] ADR_KEY2 = 15'h2AAA;

    localparam logic [7:0] KEY1_DATA  = 8'hAA;
    localparam logic [7:0] KEY2_DATA  = 8'h55;
    localparam logic [7:0] OP_PAGE    = 8'hA0;
    localparam logic [7:0] OP_EXTEND  = 8'h80;
    localparam logic [7:0] OP_ID_IN   = 8'h90;
    localparam logic [7:0] OP_ID_OUT  = 8'hF0;
    localparam logic [7:0] OP_ERASE   = 8'h10;
    localparam logic [7:0] OP_UNPROT  = 8'h20;
    localparam logic [7:0] OP_ID_ALT  = 8'h60;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_EXT,
        ST_KEY4,
        ST_KEY5
    } seq_st_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_PAGE,
        CMD_UNPROT,
        CMD_ERASE,
        CMD_ID_IN,
        CMD_ID_OUT
    } cmd_t;
endpackage

// File: rtl/unlock_seq_tracker.sv
// Sequence tracker: follows the key prefix and the command byte(s).
// Reports a finished command and a plain write combinationally for the
// current step. Assumes step is high only for a write it may decode.
module unlock_seq_tracker
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output cmd_t              cmd,
    output logic              plain
);
    seq_st_t state, nxt;
    logic    at_key1, is_key1, is_key2, miss;

    // Decode the compared address bits and key pairs.
    always_comb begin
        at_key1 = (addr[CMP_W-1:0] == ADR_KEY1);
        is_key1 = at_key1 && (data == KEY1_DATA);
        is_key2 = (addr[CMP_W-1:0] == ADR_KEY2) && (data == KEY2_DATA);
    end

    // Next state, command and miss handling with re-evaluation.
    always_comb begin
        nxt   = state;
        cmd   = CMD_NONE;
        plain = 1'b0;
        miss  = 1'b0;
        if (step) begin
            case (state)
                ST_IDLE: if (is_key1) nxt = ST_KEY1; else miss = 1'b1;
                ST_KEY1: if (is_key2) nxt = ST_KEY2; else miss = 1'b1;
                ST_KEY2: begin
                    if (at_key1 && data == OP_PAGE) begin
                        cmd = CMD_PAGE;   nxt = ST_IDLE;
                    end else if (at_key1 && data == OP_EXTEND) begin
                        nxt = ST_EXT;
                    end else if (at_key1 && data == OP_ID_IN) begin
                        cmd = CMD_ID_IN;  nxt = ST_IDLE;
                    end else if (at_key1 && data == OP_ID_OUT) begin
                        cmd = CMD_ID_OUT; nxt = ST_IDLE;
                    end else begin
                        miss = 1'b1;
                    end
                end
                ST_EXT:  if (is_key1) nxt = ST_KEY4; else miss = 1'b1;
                ST_KEY4: if (is_key2) nxt = ST_KEY5; else miss = 1'b1;
                ST_KEY5: begin
                    if (at_key1 && data == OP_ERASE) begin
                        cmd = CMD_ERASE;  nxt = ST_IDLE;
                    end else if (at_key1 && data == OP_UNPROT) begin
                        cmd = CMD_UNPROT; nxt = ST_IDLE;
                    end else if (at_key1 && data == OP_ID_ALT) begin
                        cmd = CMD_ID_IN;  nxt = ST_IDLE;
                    end else begin
                        miss = 1'b1;
                    end
                end
                default: miss = 1'b1;
            endcase
            if (miss) begin
                if (is_key1) begin
                    nxt = ST_KEY1;
                end else begin
                    nxt   = ST_IDLE;
                    plain = 1'b1;
                end
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // R11: the state only moves on a decoded write.
    a_r11_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state) |-> $past(step));

    // R4: the last key state of the long form is entered only from the one before it.
    a_r4_key5_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KEY5 && !$stable(state)) |-> $past(state) == ST_KEY4);

    // R10: a plain write leaves the tracker idle.
    a_r10_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        plain |=> state == ST_IDLE);
endmodule

// File: rtl/unlock_guard.sv
// Protection guard: holds the write-protect flag, the page window and the
// lockout. It routes writes to the tracker or straight to the load port and
// registers command pulses. Assumes cmd/plain come from the same cycle's step.
module unlock_guard
    import unlock_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int WIN_GAP     = 512,
    parameter int LOCK_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  cmd_t              cmd,
    input  logic              plain,
    output logic              step,
    output logic              load_valid,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              load_reject,
    output logic              lock_busy,
    output logic              prot_on,
    output logic              pulse_page_wr,
    output logic              pulse_unprotect,
    output logic              pulse_erase,
    output logic              pulse_id_enter,
    output logic              pulse_id_exit
);
    localparam int GAP_W  = (WIN_GAP > 1) ? $clog2(WIN_GAP) : 1;
    localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);

    logic              win_open;
    logic [GAP_W-1:0]  gap_cnt;
    logic [LOCK_W-1:0] lock_cnt;
    logic              take, win_take, bad_plain;

    // Split accepted writes between the window and the tracker.
    always_comb begin
        lock_busy = (lock_cnt != '0);
        take      = wr_valid && !lock_busy;
        win_take  = take && win_open;
        step      = take && !win_open;
        bad_plain = plain && prot_on;
    end

    // Load port and reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_valid  <= 1'b0;
            load_addr   <= '0;
            load_data   <= '0;
            load_reject <= 1'b0;
        end else begin
            load_valid  <= win_take || (plain && !prot_on);
            load_reject <= bad_plain;
            if (win_take || plain) begin
                load_addr <= addr;
                load_data <= data;
            end
        end
    end

    // Global protection flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                 prot_on <= 1'b0;
        else if (cmd == CMD_PAGE)   prot_on <= 1'b1;
        else if (cmd == CMD_UNPROT) prot_on <= 1'b0;
    end

    // Page window with its write-free gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            gap_cnt  <= '0;
        end else if (cmd == CMD_PAGE) begin
            win_open <= 1'b1;
            gap_cnt  <= '0;
        end else if (win_open) begin
            if (take) begin
                gap_cnt <= '0;
            end else if (gap_cnt == GAP_W'(WIN_GAP - 1)) begin
                win_open <= 1'b0;
                gap_cnt  <= '0;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // Lockout counter after a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n)         lock_cnt <= '0;
        else if (bad_plain) lock_cnt <= LOCK_W'(LOCK_CYCLES);
        else if (lock_busy) lock_cnt <= lock_cnt - 1'b1;
    end

    // One-cycle command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_page_wr   <= 1'b0;
            pulse_unprotect <= 1'b0;
            pulse_erase     <= 1'b0;
            pulse_id_enter  <= 1'b0;
            pulse_id_exit   <= 1'b0;
        end else begin
            pulse_page_wr   <= (cmd == CMD_PAGE);
            pulse_unprotect <= (cmd == CMD_UNPROT);
            pulse_erase     <= (cmd == CMD_ERASE);
            pulse_id_enter  <= (cmd == CMD_ID_IN);
            pulse_id_exit   <= (cmd == CMD_ID_OUT);
        end
    end

    // R8: a write during lockout causes neither a load nor a reject.
    a_r8_lock_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_busy && wr_valid) |=> (!load_valid && !load_reject));

    // R8: a reject always starts the lockout.
    a_r8_reject_locks: assert property (@(posedge clk) disable iff (!rst_n)
        load_reject |-> lock_busy);

    // R7: a load needs protection off or an open window.
    a_r7_load_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> ($past(win_open) || !$past(prot_on)));

    // R3: protection is only raised by a page-write command.
    a_r3_protect_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> pulse_page_wr);

    // R9: the window opens only with a page-write command.
    a_r9_window_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> pulse_page_wr);

    // R12: no two command pulses together.
    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pulse_page_wr, pulse_unprotect, pulse_erase,
                  pulse_id_enter, pulse_id_exit}));
endmodule

// File: rtl/unlock_id_responder.sv
// Identification responder: holds the identification-mode flag and answers
// reads at the two code addresses. Assumes cmd is valid for one cycle.
module unlock_id_responder
    import unlock_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter logic [7:0] MFR_CODE = 8'hBF,
    parameter logic [7:0] DEV_CODE = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_mode,
    output logic              id_hit,
    output logic [7:0]        id_data
);
    // Identification-mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                 id_mode <= 1'b0;
        else if (cmd == CMD_ID_IN)  id_mode <= 1'b1;
        else if (cmd == CMD_ID_OUT) id_mode <= 1'b0;
    end

    // Code lookup for reads.
    always_comb begin
        id_hit  = id_mode && (rd_addr[CMP_W-1:1] == '0);
        id_data = rd_addr[0] ? DEV_CODE : MFR_CODE;
    end

    // R5: entry follows an entry command.
    a_r5_enter_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(cmd == CMD_ID_IN));

    // R5: an exit command leaves the mode off.
    a_r5_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ID_OUT) |=> !id_mode);
endmodule

// File: rtl/unlock_seq_decoder.sv
// Top of the unlock sequence decoder: tracker, protection guard and
// identification responder. Assumes wr_valid is already synchronous and
// lasts one cycle per bus write.
module unlock_seq_decoder
    import unlock_pkg::*;
#(
    parameter int         ADDR_W      = 17,
    parameter int         WIN_GAP     = 512,
    parameter int         LOCK_CYCLES = 1024,
    parameter logic [7:0] MFR_CODE    = 8'hBF,
    parameter logic [7:0] DEV_CODE    = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              load_valid,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              load_reject,
    output logic              lock_busy,
    output logic              prot_on,
    output logic              id_mode,
    output logic              id_hit,
    output logic [7:0]        id_data,
    output logic              pulse_page_wr,
    output logic              pulse_unprotect,
    output logic              pulse_erase,
    output logic              pulse_id_enter,
    output logic              pulse_id_exit
);
    cmd_t cmd;
    logic plain, step;

    unlock_seq_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .addr  (wr_addr),
        .data  (wr_data),
        .cmd   (cmd),
        .plain (plain)
    );

    unlock_guard #(
        .ADDR_W      (ADDR_W),
        .WIN_GAP     (WIN_GAP),
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_guard (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_valid        (wr_valid),
        .addr            (wr_addr),
        .data            (wr_data),
        .cmd             (cmd),
        .plain           (plain),
        .step            (step),
        .load_valid      (load_valid),
        .load_addr       (load_addr),
        .load_data       (load_data),
        .load_reject     (load_reject),
        .lock_busy       (lock_busy),
        .prot_on         (prot_on),
        .pulse_page_wr   (pulse_page_wr),
        .pulse_unprotect (pulse_unprotect),
        .pulse_erase     (pulse_erase),
        .pulse_id_enter  (pulse_id_enter),
        .pulse_id_exit   (pulse_id_exit)
    );

    unlock_id_responder #(
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .rd_addr (rd_addr),
        .id_mode (id_mode),
        .id_hit  (id_hit),
        .id_data (id_data)
    );
endmodule

// File: tb/sim_unlock_seq_decoder.sv
// Directed bench for the unlock sequence decoder.
module sim_unlock_seq_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 17;
    localparam int GAP  = 8;
    localparam int LOCK = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          load_valid, load_reject, lock_busy, prot_on, id_mode, id_hit;
    logic [AW-1:0] load_addr;
    logic [7:0]    load_data, id_data;
    logic          p_pw, p_un, p_er, p_in, p_out;

    int checks = 0, errors = 0;
    int n_pw, n_un, n_er, n_in, n_out, n_ld, n_rej, n_multi;
    logic [AW-1:0] ld_a;
    logic [7:0]    ld_d;

    unlock_seq_decoder #(.ADDR_W(AW), .WIN_GAP(GAP), .LOCK_CYCLES(LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .load_valid(load_valid),
        .load_addr(load_addr), .load_data(load_data), .load_reject(load_reject),
        .lock_busy(lock_busy), .prot_on(prot_on), .id_mode(id_mode),
        .id_hit(id_hit), .id_data(id_data), .pulse_page_wr(p_pw),
        .pulse_unprotect(p_un), .pulse_erase(p_er), .pulse_id_enter(p_in),
        .pulse_id_exit(p_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Event monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_pw  += int'(p_pw);
            n_un  += int'(p_un);
            n_er  += int'(p_er);
            n_in  += int'(p_in);
            n_out += int'(p_out);
            n_rej += int'(load_reject);
            if (load_valid) begin
                n_ld++;
                ld_a = load_addr;
                ld_d = load_data;
            end
            if (int'(p_pw) + int'(p_un) + int'(p_er) + int'(p_in) + int'(p_out) > 1)
                n_multi++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        n_pw = 0; n_un = 0; n_er = 0; n_in = 0; n_out = 0;
        n_ld = 0; n_rej = 0; ld_a = '0; ld_d = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_addr  = a;
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic key3(input logic [7:0] op);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, op);
    endtask

    task automatic key6(input logic [7:0] op);
        key3(8'h80);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, op);
    endtask

    task automatic wait_unlock();
        for (int i = 0; i < 4 * LOCK && lock_busy; i++) idle(1);
    endtask

    task automatic t_reset();
        check("R1 prot", int'(prot_on), 0);
        check("R1 id", int'(id_mode), 0);
        check("R1 busy", int'(lock_busy), 0);
        check("R1 outs", int'({load_valid, load_reject, p_pw, p_un, p_er, p_in, p_out}), 0);
        rd_addr = '0; #1;
        check("R1 no id hit", int'(id_hit), 0);
    endtask

    task automatic t_plain_open();
        clr();
        wr(17'h1ABCD, 8'h3C);
        check("R7 load count", n_ld, 1);
        check("R7 load addr", int'(ld_a), 'h1ABCD);
        check("R7 load data", int'(ld_d), 'h3C);
        check("R7 no reject", n_rej, 0);
    endtask

    task automatic t_restart();
        clr();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h00123, 8'h5A);
        check("R11 keys not loaded", n_ld, 1);
        check("R10 stray loaded addr", int'(ld_a), 'h123);
        check("R10 stray loaded data", int'(ld_d), 'h5A);
        clr();
        wr(17'h15555, 8'hAA);
        wr(17'h0D555, 8'hAA);   // repeated first key restarts
        wr(17'h12AAA, 8'h55);
        wr(17'h15555, 8'h90);
        check("R2 R10 id enter", n_in, 1);
        check("R11 no loads", n_ld, 0);
        check("R5 id mode set", int'(id_mode), 1);
    endtask

    task automatic t_id_read();
        rd_addr = 17'h00000; #1;
        check("R6 hit mfr", int'(id_hit), 1);
        check("R6 mfr code", int'(id_data), 'hBF);
        rd_addr = 17'h10001; #1;
        check("R6 hit dev", int'(id_hit), 1);
        check("R6 dev code", int'(id_data), 'h07);
        rd_addr = 17'h00002; #1;
        check("R6 other addr", int'(id_hit), 0);
        clr();
        key3(8'hF0);
        check("R5 exit pulse", n_out, 1);
        check("R5 id mode off", int'(id_mode), 0);
        rd_addr = 17'h00000; #1;
        check("R6 no hit off", int'(id_hit), 0);
    endtask

    task automatic t_long_forms();
        clr();
        key6(8'h60);
        check("R4 alt id enter", n_in, 1);
        check("R4 alt id mode", int'(id_mode), 1);
        key3(8'hF0);
        clr();
        key6(8'h10);
        check("R4 erase pulse", n_er, 1);
        check("R4 erase keeps prot", int'(prot_on), 0);
        check("R11 erase no load", n_ld, 0);
        clr();
        key6(8'h33);
        check("R4 bad sixth no cmd", n_pw + n_un + n_er + n_in + n_out, 0);
        check("R10 bad sixth loaded", int'(ld_d), 'h33);
    endtask

    task automatic t_window();
        clr();
        key3(8'hA0);
        check("R3 page pulse", n_pw, 1);
        check("R3 prot on", int'(prot_on), 1);
        wr(17'h00100, 8'h11);
        idle(GAP - 1);
        wr(17'h05555, 8'hAA);   // in window: data, not decoded
        check("R9 loads in window", n_ld, 2);
        check("R9 last load data", int'(ld_d), 'hAA);
        idle(GAP);
        wr(17'h00102, 8'h33);
        check("R9 closed rejects", n_rej, 1);
        check("R9 closed no load", n_ld, 2);
        wait_unlock();
    endtask

    task automatic t_lockout();
        int n;
        clr();
        wr(17'h00200, 8'h44);
        check("R8 reject", n_rej, 1);
        check("R8 no load", n_ld, 0);
        n = 0;
        for (int i = 0; i < 4 * LOCK && lock_busy; i++) begin
            n++;
            idle(1);
        end
        check("R8 lock length", n, LOCK);
        clr();
        wr(17'h00201, 8'h45);
        key6(8'h20);
        check("R8 unprotect ignored", n_un, 0);
        check("R8 prot kept", int'(prot_on), 1);
        check("R8 one reject only", n_rej, 1);
        wait_unlock();
    endtask

    task automatic t_reprotect();
        clr();
        key3(8'hA0);
        check("R3 page while on", n_pw, 1);
        wr(17'h00300, 8'h77);
        check("R3 window load", n_ld, 1);
        idle(GAP + 2);
    endtask

    task automatic t_unprotect();
        clr();
        key6(8'h20);
        check("R4 unprotect pulse", n_un, 1);
        check("R4 prot off", int'(prot_on), 0);
        wr(17'h00400, 8'h88);
        check("R7 load after unprotect", n_ld, 1);
    endtask

    task automatic t_protected_miss();
        key3(8'hA0);
        idle(GAP + 2);
        clr();
        wr(17'h05555, 8'hAA);
        check("R10 key not rejected", n_rej, 0);
        wr(17'h00500, 8'h12);
        check("R10 R8 miss rejected", n_rej, 1);
        check("R10 miss no load", n_ld, 0);
        wait_unlock();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        n_multi = 0;
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_plain_open();
        t_restart();
        t_id_read();
        t_long_forms();
        t_window();
        t_lockout();
        t_reprotect();
        t_unprotect();
        t_protected_miss();
        check("R12 single pulse", n_multi, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule